// File: doc/BRIEF.md
# Audio Serial Clock Ratio Generator

This block produces the bit clock and the frame (left/right) clock for a serial audio port. Its clock is the port's master clock. Two coded fields set the clock ratios. The first gives the number of master-clock cycles in one frame. The second gives the number of bit clocks in one frame. The bit-clock divider is the first of these divided by the second. One free-running counter, cleared whenever the port is stopped, supplies both output levels.

The port has two directions, output and input. Each direction selects its own role. In the master role it drives the internally generated clocks and raises its drive enable. In the slave role it passes the clocks arriving from outside and keeps its drive enable low. Each role has its own pair of polarity inversions, one for the bit clock and one for the frame clock. A single port enable gates every clock output and every drive enable. Software programs the ratio fields first and sets the enable afterwards. A ratio combination the block cannot produce raises an error flag and holds the generated clocks idle.

Top module: `audclk_ratio_gen`

## Requirements
- R1: `frm_ratio` sets the master-clock cycles per frame, which is the frame clock period: code 0 gives 512, 1 gives 256, 2 gives 128, 3 gives 64 and 4 gives 32. The frame clock is low for the first half of each period and high for the second half.
- R2: `bits_code` sets the bit clocks per frame: code 0 gives 32, 1 gives 64, 2 gives 128, 3 gives 256, 4 gives 512 and 7 gives 16. The bit clock period is the frame period divided by this count. The bit clock is low for the first half of each bit period and high for the second half.
- R3: A reserved code raises `cfg_err` combinationally and holds both generated clocks low while the port is enabled. The reserved codes are 5 and 6 in `bits_code`, and 5, 6 and 7 in `frm_ratio`.
- R4: A combination whose bit period would be shorter than two master cycles raises `cfg_err` and holds the generated clocks low. This covers a frame period equal to or smaller than the bit count.
- R5: The frame clock changes level once every half frame, which is half the bit count of bit clocks. Every frame clock edge falls in a cycle where the generated bit clock is low.
- R6: Both generated clocks are low in the first cycle after the clock edge that first samples `port_en` high. If t counts master cycles from that edge, the bit clock is first high at t equal to half the bit period.
- R7: While `port_en` is low, every bit of `dir_bclk`, `dir_fclk` and `dir_clk_oe` is 0, whatever the role and inversion settings. This takes effect combinationally.
- R8: Bit 0 of `dir_master` selects the master role for the output direction and bit 1 selects it for the input direction. A direction in the master role drives the generated clocks and sets its `dir_clk_oe` bit.
- R9: A direction in the slave role passes `ext_bclk` and `ext_fclk` through combinationally and keeps its `dir_clk_oe` bit at 0.
- R10: `inv_bclk_mst` and `inv_fclk_mst` invert the bit and frame clocks of directions in the master role only.
- R11: `inv_bclk_slv` and `inv_fclk_slv` invert the bit and frame clocks of directions in the slave role only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Port clock enable |
| frm_ratio | input | 3 | Coded master cycles per frame |
| bits_code | input | 3 | Coded bit clocks per frame |
| dir_master | input | 2 | Role per direction, 1 = master (bit 0 output, bit 1 input) |
| inv_bclk_mst | input | 1 | Invert bit clock in master role |
| inv_fclk_mst | input | 1 | Invert frame clock in master role |
| inv_bclk_slv | input | 1 | Invert bit clock in slave role |
| inv_fclk_slv | input | 1 | Invert frame clock in slave role |
| ext_bclk | input | 1 | Bit clock received in slave role |
| ext_fclk | input | 1 | Frame clock received in slave role |
| dir_bclk | output | 2 | Bit clock per direction |
| dir_fclk | output | 2 | Frame clock per direction |
| dir_clk_oe | output | 2 | Clock drive enable per direction |
| cfg_err | output | 1 | Unsupported ratio combination |

## Verification
The bench goes after the extreme combinations of the two fields. At one end is the shortest legal bit period of two master cycles. At the other are the combinations with a divider of one or of a fraction. A design that computes the divider wrongly would toggle the bit clock at the master rate, or would wrap its counter and produce a garbage period, instead of flagging an error. The first cycles after the enable are checked exactly, to catch a counter that starts at one or clocks that come up high. The bench also crosses roles with inversion. This catches a design that applies a master inversion to the slave path, or the reverse. It also catches a design that leaves inverted clocks high while the port is disabled.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  // largest log2 of master cycles per frame (512)
  localparam int MAX_SH = 9;
  localparam int SH_W   = $clog2(MAX_SH + 1);

  typedef struct packed {
    logic            err;
    logic [SH_W-1:0] bit_sh;  // log2 master cycles per bit
    logic [SH_W-1:0] frm_sh;  // log2 master cycles per frame
  } ratio_cfg_t;

  // log2 of master cycles per frame; zero marks a reserved code
  function automatic logic [SH_W-1:0] frame_shift(input logic [2:0] code);
    case (code)
      3'd0:    return SH_W'(9);
      3'd1:    return SH_W'(8);
      3'd2:    return SH_W'(7);
      3'd3:    return SH_W'(6);
      3'd4:    return SH_W'(5);
      default: return '0;
    endcase
  endfunction

  // log2 of bit clocks per frame; zero marks a reserved code
  function automatic logic [SH_W-1:0] bits_shift(input logic [2:0] code);
    case (code)
      3'd0:    return SH_W'(5);
      3'd1:    return SH_W'(6);
      3'd2:    return SH_W'(7);
      3'd3:    return SH_W'(8);
      3'd4:    return SH_W'(9);
      3'd7:    return SH_W'(4);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ratio_decode.sv
module ratio_decode
  import audclk_pkg::*;
(
  input  logic [2:0]  frm_ratio,
  input  logic [2:0]  bits_code,
  output ratio_cfg_t  cfg
);
  logic [SH_W-1:0] fsh;
  logic [SH_W-1:0] bsh;

  always_comb begin
    fsh        = frame_shift(frm_ratio);
    bsh        = bits_shift(bits_code);
    // reserved code, or a bit period under two master cycles
    cfg.err    = (fsh == '0) || (bsh == '0) || (fsh <= bsh);
    cfg.bit_sh = cfg.err ? '0 : (fsh - bsh);
    cfg.frm_sh = cfg.err ? '0 : fsh;
  end
endmodule

// File: rtl/clk_divider.sv
module clk_divider
  import audclk_pkg::*;
#(
  parameter int CNT_W = MAX_SH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [SH_W-1:0] bit_sh,
  input  logic [SH_W-1:0] frm_sh,
  output logic            run,
  output logic            bclk_lvl,
  output logic            fclk_lvl
);
  logic [CNT_W-1:0] mcnt;
  logic [CNT_W-1:0] bit_tap;
  logic [CNT_W-1:0] frm_tap;
  logic [SH_W-1:0]  bit_idx;
  logic [SH_W-1:0]  frm_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      mcnt <= '0;
    end else begin
      run <= start;
      if (!start)   mcnt <= '0;
      else if (run) mcnt <= mcnt + 1'b1;
    end
  end

  always_comb begin
    bit_idx  = bit_sh - 1'b1;
    frm_idx  = frm_sh - 1'b1;
    bit_tap  = mcnt >> bit_idx;
    frm_tap  = mcnt >> frm_idx;
    bclk_lvl = run & bit_tap[0];
    fclk_lvl = run & frm_tap[0];
  end

  // R6
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (!bclk_lvl && !fclk_lvl));

  // R5
  frame_edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fclk_lvl) || $fell(fclk_lvl)) |-> !bclk_lvl);
endmodule

// File: rtl/dir_clk_sel.sv
module dir_clk_sel (
  input  logic en,
  input  logic master,
  input  logic gen_b,
  input  logic gen_f,
  input  logic ext_b,
  input  logic ext_f,
  input  logic inv_b_m,
  input  logic inv_f_m,
  input  logic inv_b_s,
  input  logic inv_f_s,
  output logic bclk,
  output logic fclk,
  output logic oe
);
  always_comb begin
    bclk = en & (master ? (gen_b ^ inv_b_m) : (ext_b ^ inv_b_s));
    fclk = en & (master ? (gen_f ^ inv_f_m) : (ext_f ^ inv_f_s));
    oe   = en & master;
  end
endmodule

// File: rtl/audclk_ratio_gen.sv
module audclk_ratio_gen
  import audclk_pkg::*;
#(
  parameter int NUM_DIR = 2,
  parameter int CNT_W   = MAX_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en,
  input  logic [2:0]         frm_ratio,
  input  logic [2:0]         bits_code,
  input  logic [NUM_DIR-1:0] dir_master,
  input  logic               inv_bclk_mst,
  input  logic               inv_fclk_mst,
  input  logic               inv_bclk_slv,
  input  logic               inv_fclk_slv,
  input  logic               ext_bclk,
  input  logic               ext_fclk,
  output logic [NUM_DIR-1:0] dir_bclk,
  output logic [NUM_DIR-1:0] dir_fclk,
  output logic [NUM_DIR-1:0] dir_clk_oe,
  output logic               cfg_err
);
  ratio_cfg_t cfg;
  logic       gen_run;
  logic       gen_bclk;
  logic       gen_fclk;

  ratio_decode u_dec (
    .frm_ratio (frm_ratio),
    .bits_code (bits_code),
    .cfg       (cfg)
  );

  clk_divider #(.CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (port_en & ~cfg.err),
    .bit_sh   (cfg.bit_sh),
    .frm_sh   (cfg.frm_sh),
    .run      (gen_run),
    .bclk_lvl (gen_bclk),
    .fclk_lvl (gen_fclk)
  );

  assign cfg_err = cfg.err;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    dir_clk_sel u_sel (
      .en      (port_en),
      .master  (dir_master[d]),
      .gen_b   (gen_bclk),
      .gen_f   (gen_fclk),
      .ext_b   (ext_bclk),
      .ext_f   (ext_fclk),
      .inv_b_m (inv_bclk_mst),
      .inv_f_m (inv_fclk_mst),
      .inv_b_s (inv_bclk_slv),
      .inv_f_s (inv_fclk_slv),
      .bclk    (dir_bclk[d]),
      .fclk    (dir_fclk[d]),
      .oe      (dir_clk_oe[d])
    );
  end

  // R3 R4
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(cfg_err)) |-> (!gen_run && !gen_bclk && !gen_fclk));

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> (dir_bclk == '0 && dir_fclk == '0 && dir_clk_oe == '0));
endmodule

// File: tb/audclk_ratio_gen_test.sv
module audclk_ratio_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam int V_MCK [NV] = '{0, 1, 2, 3, 4, 4, 3, 0, 1, 5, 0, 0};
  localparam int V_BPF [NV] = '{0, 1, 7, 0, 7, 0, 2, 5, 6, 0, 4, 3};
  localparam int V_R   [NV] = '{512, 256, 128, 64, 32, 32, 64, 512, 256, 0, 512, 512};
  // bit period in master cycles; 0 marks an expected error
  localparam int V_D   [NV] = '{16, 4, 8, 2, 2, 0, 0, 0, 0, 0, 0, 2};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0;
  logic [2:0] frm_ratio = '0;
  logic [2:0] bits_code = '0;
  logic [1:0] dir_master = '0;
  logic       inv_bclk_mst = 1'b0, inv_fclk_mst = 1'b0;
  logic       inv_bclk_slv = 1'b0, inv_fclk_slv = 1'b0;
  logic       ext_bclk = 1'b0, ext_fclk = 1'b0;
  logic [1:0] dir_bclk, dir_fclk, dir_clk_oe;
  logic       cfg_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audclk_ratio_gen uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en),
    .frm_ratio(frm_ratio), .bits_code(bits_code), .dir_master(dir_master),
    .inv_bclk_mst(inv_bclk_mst), .inv_fclk_mst(inv_fclk_mst),
    .inv_bclk_slv(inv_bclk_slv), .inv_fclk_slv(inv_fclk_slv),
    .ext_bclk(ext_bclk), .ext_fclk(ext_fclk),
    .dir_bclk(dir_bclk), .dir_fclk(dir_fclk), .dir_clk_oe(dir_clk_oe),
    .cfg_err(cfg_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // stop, then enable; returns at the negedge where t = 0
  task automatic restart();
    @(negedge clk); port_en = 1'b0;
    @(negedge clk); port_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_vec(input int i);
    int mis_b, mis_f, mis_e;
    string etag;
    mis_b = 0; mis_f = 0; mis_e = 0;
    @(negedge clk);
    port_en = 1'b0;
    frm_ratio = 3'(V_MCK[i]);
    bits_code = 3'(V_BPF[i]);
    dir_master = 2'b01;
    {inv_bclk_mst, inv_fclk_mst, inv_bclk_slv, inv_fclk_slv} = '0;
    @(negedge clk);
    etag = (V_BPF[i] == 5 || V_BPF[i] == 6 || V_MCK[i] > 4) ? "R3" : "R4";
    check((V_D[i] == 0) ? etag : "R1 R2", $sformatf("cfg_err vec %0d", i),
          32'(cfg_err), 32'(V_D[i] == 0));
    port_en = 1'b1;
    if (V_D[i] == 0) begin
      for (int t = 0; t < 8; t++) begin
        @(negedge clk);
        if (dir_bclk[0] || dir_fclk[0]) mis_e++;
      end
      check(etag, $sformatf("idle clocks vec %0d", i), 32'(mis_e), 32'd0);
    end else begin
      for (int t = 0; t < 2 * V_R[i]; t++) begin
        logic eb, ef;
        @(negedge clk);
        eb = (t % V_D[i]) >= (V_D[i] / 2);
        ef = (t % V_R[i]) >= (V_R[i] / 2);
        if (t == 0)
          check("R6", $sformatf("start low vec %0d", i),
                32'({dir_bclk[0], dir_fclk[0]}), 32'd0);
        if (dir_bclk[0] !== eb) mis_b++;
        if (dir_fclk[0] !== ef) mis_f++;
      end
      check("R2", $sformatf("bit clock mismatches vec %0d", i), 32'(mis_b), 32'd0);
      check("R1 R5", $sformatf("frame clock mismatches vec %0d", i), 32'(mis_f), 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R7", "reset outputs", 32'({dir_bclk, dir_fclk, dir_clk_oe}), 32'd0);
    check("R1", "reset cfg_err", 32'(cfg_err), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(i);

    // R7: drop enable while the bit clock is high
    frm_ratio = 3'd3; bits_code = 3'd0; dir_master = 2'b01;
    restart();
    @(negedge clk);
    check("R7", "bclk high before disable", 32'(dir_bclk[0]), 32'd1);
    port_en = 1'b0; #1;
    check("R7", "disabled outputs", 32'({dir_bclk, dir_fclk, dir_clk_oe}), 32'd0);
    inv_bclk_mst = 1'b1; inv_bclk_slv = 1'b1; #1;
    check("R7", "disabled with inversion", 32'({dir_bclk, dir_fclk}), 32'd0);
    inv_bclk_mst = 1'b0; inv_bclk_slv = 1'b0;

    // R8: input direction master, output direction slave
    dir_master = 2'b10; ext_bclk = 1'b0; ext_fclk = 1'b0;
    restart();
    check("R8", "oe input master", 32'(dir_clk_oe), 32'b10);
    @(negedge clk);
    check("R8", "bclk input master t1", 32'(dir_bclk), 32'b10);

    // R9 R11: both slave
    dir_master = 2'b00; ext_bclk = 1'b1; ext_fclk = 1'b1; #1;
    check("R9", "slave bclk pass", 32'(dir_bclk), 32'b11);
    check("R9", "slave fclk pass and oe", 32'({dir_fclk, dir_clk_oe}), 32'b1100);
    inv_bclk_slv = 1'b1; #1;
    check("R11", "slave bclk inverted", 32'({dir_bclk, dir_fclk}), 32'b0011);
    inv_bclk_slv = 1'b0; inv_fclk_slv = 1'b1; #1;
    check("R11", "slave fclk inverted", 32'({dir_bclk, dir_fclk}), 32'b1100);
    inv_fclk_slv = 1'b0;

    // R10 R11: master inversion leaves the slave direction alone
    dir_master = 2'b01; ext_bclk = 1'b0; ext_fclk = 1'b0;
    inv_bclk_mst = 1'b1; inv_fclk_mst = 1'b1;
    restart();
    check("R10", "master inverted bclk", 32'(dir_bclk), 32'b01);
    check("R10 R11", "master inverted fclk", 32'(dir_fclk), 32'b01);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule